// File: doc/BRIEF.md
# AX.25 Multi-Frame Bit Serializer

This block turns one or more frames held in an external buffer into the raw bit sequence of one keyed transmission. A transmission opens with a run of preamble flags and then a short group of header flags. Each frame follows as its payload bytes, its 16-bit frame check sequence and a group of separating flags. A run of tail flags closes the transmission. Payload and check-sequence bits are bit-stuffed. Flag bits are not.

The block does no modulation and no NRZI coding. A downstream modulator pulses a request input once per bit time, and the serializer presents the next bit on a registered output. The frames stay in a buffer owned by the caller. The block drives a frame select and a byte select, and the buffer answers in the same cycle with that frame's length and the addressed byte. A single start pulse launches the whole chain of frames, and a one-cycle done pulse marks the last tail bit.

Top module: `ax25_bit_serializer`

## Requirements
- R1: During and after reset, with no start, `busy_o`, `done_o` and `bit_o` are all 0.
- R2: A `start_i` pulse while idle with a nonzero `frame_count_i` raises `busy_o` on the next cycle. A start while busy, or with a frame count of 0, is ignored.
- R3: Each cycle in which `bit_req_i` is high while busy hands out exactly one bit, which appears on `bit_o` after that clock edge. `bit_o` holds its value in every cycle without a request, and requests while idle have no effect on any output.
- R4: The transmission starts with PRE_FLAGS flags followed by HDR_FLAGS flags. A flag is the byte 0x7E sent LSB first, which gives the bit order 0,1,1,1,1,1,1,0, and flag bits are never stuffed.
- R5: Frames are sent in index order 0 to count-1. Within a frame, bytes go from address 0 to length-1, and each byte is sent LSB first.
- R6: In payload and check-sequence bits, a 0 is inserted directly after every run of five consecutive 1s, and the run count then restarts. A run that ends on the last check-sequence bit still gets its 0 before the next flag.
- R7: The check sequence is the 16-bit complement of a reflected CRC with polynomial 0x8408 and initial value 0xFFFF over the payload bits, sent as bits 0..15, which is low byte first and LSB first. The bytes "123456789" give 0x906E, and an empty frame gives sixteen 0 bits.
- R8: Every frame's check sequence is followed by SEP_FLAGS flags. After the last frame's separating flags come TAIL_FLAGS flags.
- R9: `done_o` is high for exactly one cycle, in the cycle that the last tail bit appears on `bit_o`. In that same cycle `busy_o` is already 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that launches a transmission |
| frame_count_i | input | CNT_W | Number of frames to send, sampled with start_i |
| frame_sel_o | output | IDX_W | Index of the frame currently being read from the buffer |
| byte_sel_o | output | ADDR_W | Byte address within the selected frame |
| byte_i | input | 8 | Buffer byte at frame_sel_o / byte_sel_o, valid in the same cycle |
| frame_len_i | input | LEN_W | Length in bytes of the frame at frame_sel_o, valid in the same cycle |
| bit_req_i | input | 1 | Modulator request for the next bit |
| bit_o | output | 1 | Current serial bit |
| busy_o | output | 1 | High while a transmission is in progress |
| done_o | output | 1 | One-cycle pulse with the last tail bit |

## Verification
Every result is due exactly one clock edge after its cause. `busy_o` follows the edge that captures the start, and each new `bit_o` follows the edge that sees its request. `done_o` and the fall of `busy_o` come with the edge of the final request. The bench drives every input at a falling edge and reads the outputs at the next falling edge, so each comparison lands half a cycle after the rising edge that was meant to update them. Bit-by-bit comparison runs once with a request held high every cycle and again with idle gaps between requests. In the runs with gaps, the bench also checks that the output holds its value through each gap.

// File: rtl/ax25_ser_pkg.sv
// Shared definitions for the AX.25 bit serializer: the transmission
// phases, the flag pattern and the reflected CRC polynomial.
package ax25_ser_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_HDR,
        PH_DATA,
        PH_FCS,
        PH_SEP,
        PH_TAIL
    } phase_t;

    localparam logic [7:0]  FLAG_BYTE    = 8'h7E;
    localparam logic [15:0] CRC_POLY_REV = 16'h8408;
    localparam logic [15:0] CRC_INIT     = 16'hFFFF;
    localparam int          STUFF_RUN    = 5;

endpackage

// File: rtl/ax25_fcs_engine.sv
// Bit-serial reflected CRC-16 register.
// Assumes: clear_i and shift_i never rise together. The caller
// complements crc_o to form the transmitted check sequence.
module ax25_fcs_engine #(
    parameter logic [15:0] POLY_REV = 16'h8408,
    parameter logic [15:0] INIT     = 16'hFFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear_i,
    input  logic        shift_i,
    input  logic        bit_i,
    output logic [15:0] crc_o
);

    logic [15:0] crc_q;
    logic        fb;

    // feedback bit of the LSB-first shift
    assign fb = crc_q[0] ^ bit_i;

    // preset at frame start, fold in one payload bit per shift
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= INIT;
        end else if (clear_i) begin
            crc_q <= INIT;
        end else if (shift_i) begin
            crc_q <= (crc_q >> 1) ^ ({16{fb}} & POLY_REV);
        end
    end

    assign crc_o = crc_q;

endmodule

// File: rtl/ax25_stuff_tracker.sv
// Counts consecutive 1s handed out in stuffable regions and flags when a
// zero must be inserted. Assumes: take_i marks every bit that leaves the
// block, including the inserted zeros, and countable_i describes that bit.
module ax25_stuff_tracker #(
    parameter int RUN_LEN = 5,
    localparam int RUN_W  = $clog2(RUN_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             take_i,
    input  logic             countable_i,
    input  logic             bit_i,
    output logic             due_o,
    output logic [RUN_W-1:0] run_o
);

    logic [RUN_W-1:0] run_q;

    assign due_o = (run_q == RUN_W'(RUN_LEN));

    // update the run length on every bit handed out
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            run_q <= '0;
        end else if (take_i) begin
            if (due_o)
                run_q <= '0;
            else if (countable_i && bit_i)
                run_q <= run_q + 1'b1;
            else
                run_q <= '0;
        end
    end

    assign run_o = run_q;

endmodule

// File: rtl/ax25_bit_serializer.sv
// Top of the AX.25 bit serializer. It sequences the preamble, header,
// frame, check-sequence, separator and tail phases, and hands out one bit
// per modulator request. Assumes: the buffer answers frame_len_i and byte_i
// combinationally for the selects, every frame length is at most MAX_BYTES,
// the frame count is at most MAX_FRAMES, each flag count is at least 1, and
// buffer contents stay unchanged while busy_o is high.
module ax25_bit_serializer
    import ax25_ser_pkg::*;
#(
    parameter int MAX_FRAMES = 8,
    parameter int MAX_BYTES  = 64,
    parameter int PRE_FLAGS  = 32,
    parameter int HDR_FLAGS  = 2,
    parameter int SEP_FLAGS  = 2,
    parameter int TAIL_FLAGS = 2,
    localparam int IDX_W  = (MAX_FRAMES > 1) ? $clog2(MAX_FRAMES) : 1,
    localparam int CNT_W  = $clog2(MAX_FRAMES + 1),
    localparam int ADDR_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1,
    localparam int LEN_W  = $clog2(MAX_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  frame_count_i,
    output logic [IDX_W-1:0]  frame_sel_o,
    output logic [ADDR_W-1:0] byte_sel_o,
    input  logic [7:0]        byte_i,
    input  logic [LEN_W-1:0]  frame_len_i,
    input  logic              bit_req_i,
    output logic              bit_o,
    output logic              busy_o,
    output logic              done_o
);

    localparam int FMAX_A = (PRE_FLAGS > HDR_FLAGS) ? PRE_FLAGS : HDR_FLAGS;
    localparam int FMAX_B = (SEP_FLAGS > TAIL_FLAGS) ? SEP_FLAGS : TAIL_FLAGS;
    localparam int FMAX   = (FMAX_A > FMAX_B) ? FMAX_A : FMAX_B;
    localparam int FLAG_W = (FMAX > 1) ? $clog2(FMAX) : 1;
    localparam int RUN_W  = $clog2(STUFF_RUN + 1);

    phase_t            phase_q;
    phase_t            flag_next;
    logic [3:0]        bitpos_q;
    logic [FLAG_W-1:0] flagnum_q;
    logic [FLAG_W-1:0] flag_last;
    logic [CNT_W-1:0]  frame_q;
    logic [CNT_W-1:0]  total_q;
    logic [ADDR_W-1:0] byte_q;
    logic              bit_q;
    logic              done_q;

    logic              active;
    logic              take;
    logic              advance;
    logic              launch;
    logic              flag_phase;
    logic              flag_end;
    logic              last_byte;
    logic              cur_bit;
    logic              stuff_due;
    logic              countable;
    logic              crc_clear;
    logic              crc_shift;
    logic [15:0]       crc_val;
    logic [RUN_W-1:0]  stuff_run;

    assign active    = (phase_q != PH_IDLE);
    assign take      = bit_req_i && active;
    assign advance   = take && !stuff_due;
    assign launch    = !active && start_i && (frame_count_i != '0);
    assign countable = (phase_q == PH_DATA) || (phase_q == PH_FCS);

    // decide whether the current phase is a flag phase and its last flag index
    always_comb begin
        flag_phase = 1'b1;
        flag_last  = '0;
        case (phase_q)
            PH_PRE:  flag_last = FLAG_W'(PRE_FLAGS - 1);
            PH_HDR:  flag_last = FLAG_W'(HDR_FLAGS - 1);
            PH_SEP:  flag_last = FLAG_W'(SEP_FLAGS - 1);
            PH_TAIL: flag_last = FLAG_W'(TAIL_FLAGS - 1);
            default: flag_phase = 1'b0;
        endcase
    end

    assign flag_end  = flag_phase && (bitpos_q[2:0] == 3'd7) && (flagnum_q == flag_last);
    assign last_byte = (LEN_W'(byte_q) + 1'b1) == frame_len_i;

    // choose the phase that follows the last flag of a flag phase
    always_comb begin
        flag_next = PH_IDLE;
        case (phase_q)
            PH_PRE:  flag_next = PH_HDR;
            PH_HDR:  flag_next = (frame_len_i == '0) ? PH_FCS : PH_DATA;
            PH_SEP:  flag_next = (frame_q == total_q) ? PH_TAIL :
                                 ((frame_len_i == '0) ? PH_FCS : PH_DATA);
            default: flag_next = PH_IDLE;
        endcase
    end

    // select the bit the current phase would hand out next
    always_comb begin
        case (phase_q)
            PH_DATA: cur_bit = byte_i[bitpos_q[2:0]];
            PH_FCS:  cur_bit = ~crc_val[bitpos_q];
            PH_IDLE: cur_bit = 1'b0;
            default: cur_bit = FLAG_BYTE[bitpos_q[2:0]];
        endcase
    end

    assign crc_clear = advance && flag_end &&
                       ((flag_next == PH_DATA) || (flag_next == PH_FCS));
    assign crc_shift = advance && (phase_q == PH_DATA);

    ax25_fcs_engine #(
        .POLY_REV (CRC_POLY_REV),
        .INIT     (CRC_INIT)
    ) u_fcs (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (crc_clear),
        .shift_i (crc_shift),
        .bit_i   (cur_bit),
        .crc_o   (crc_val)
    );

    ax25_stuff_tracker #(
        .RUN_LEN (STUFF_RUN)
    ) u_stuff (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart_i   (launch),
        .take_i      (take),
        .countable_i (countable),
        .bit_i       (cur_bit),
        .due_o       (stuff_due),
        .run_o       (stuff_run)
    );

    // phase sequencing, counters and the registered serial bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_IDLE;
            bitpos_q  <= '0;
            flagnum_q <= '0;
            frame_q   <= '0;
            total_q   <= '0;
            byte_q    <= '0;
            bit_q     <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (launch) begin
                phase_q   <= PH_PRE;
                bitpos_q  <= '0;
                flagnum_q <= '0;
                frame_q   <= '0;
                byte_q    <= '0;
                total_q   <= frame_count_i;
            end else if (take) begin
                bit_q <= stuff_due ? 1'b0 : cur_bit;
                if (!stuff_due) begin
                    case (phase_q)
                        PH_DATA: begin
                            if (bitpos_q[2:0] == 3'd7) begin
                                bitpos_q <= '0;
                                if (last_byte) begin
                                    byte_q  <= '0;
                                    phase_q <= PH_FCS;
                                end else begin
                                    byte_q <= byte_q + 1'b1;
                                end
                            end else begin
                                bitpos_q <= bitpos_q + 1'b1;
                            end
                        end
                        PH_FCS: begin
                            if (bitpos_q == 4'd15) begin
                                bitpos_q <= '0;
                                frame_q  <= frame_q + 1'b1;
                                phase_q  <= PH_SEP;
                            end else begin
                                bitpos_q <= bitpos_q + 1'b1;
                            end
                        end
                        default: begin
                            if (bitpos_q[2:0] == 3'd7) begin
                                bitpos_q <= '0;
                                if (flag_end) begin
                                    flagnum_q <= '0;
                                    phase_q   <= flag_next;
                                    if (phase_q == PH_TAIL)
                                        done_q <= 1'b1;
                                end else begin
                                    flagnum_q <= flagnum_q + 1'b1;
                                end
                            end else begin
                                bitpos_q <= bitpos_q + 1'b1;
                            end
                        end
                    endcase
                end
            end
        end
    end

    assign frame_sel_o = frame_q[IDX_W-1:0];
    assign byte_sel_o  = byte_q;
    assign bit_o       = bit_q;
    assign busy_o      = active;
    assign done_o      = done_q;

endmodule

// File: rtl/ax25_bit_serializer_chk.sv
// Property checker for ax25_bit_serializer, attached by bind. It watches
// the ports and the stuffing run length, which the tracker drives.
module ax25_bit_serializer_chk #(
    parameter int CNT_W = 4,
    parameter int RUN_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [CNT_W-1:0] frame_count_i,
    input logic             bit_req_i,
    input logic             bit_o,
    input logic             busy_o,
    input logic             done_o,
    input logic [RUN_W-1:0] run_i
);

    a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && frame_count_i != '0) |=> busy_o);

    a_r2_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && frame_count_i == '0) |=> !busy_o);

    a_r3_hold_bit: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_req_i |=> $stable(bit_o));

    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> !done_o);

    a_r6_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run_i <= RUN_W'(5));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    a_r9_done_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(bit_req_i));

endmodule

bind ax25_bit_serializer ax25_bit_serializer_chk #(
    .CNT_W (CNT_W),
    .RUN_W (RUN_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .frame_count_i (frame_count_i),
    .bit_req_i     (bit_req_i),
    .bit_o         (bit_o),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .run_i         (stuff_run)
);

// File: tb/sim_ax25_bit_serializer.sv
// Bench for ax25_bit_serializer: a vector table of transmissions compared
// bit by bit with a model built from the requirements, then directed tests.
module sim_ax25_bit_serializer;

    localparam int MAXF  = 8;
    localparam int MAXB  = 64;
    localparam int PRE   = 32;
    localparam int HDR   = 2;
    localparam int SEP   = 2;
    localparam int TAIL  = 2;
    localparam int NBITS = 8192;
    localparam int HEAD_BITS = (PRE + HDR) * 8;

    // fields: frames, len of frame 0, len of others, fill mode, request gap
    localparam logic [39:0] VEC [6] = '{
        {8'd1, 8'd9,  8'd0, 8'd2, 8'd0},
        {8'd1, 8'd5,  8'd0, 8'd1, 8'd2},
        {8'd3, 8'd4,  8'd6, 8'd0, 8'd1},
        {8'd2, 8'd0,  8'd3, 8'd0, 8'd0},
        {8'd4, 8'd2,  8'd1, 8'd3, 8'd3},
        {8'd1, 8'd64, 8'd0, 8'd0, 8'd0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [3:0] frame_count_i = '0;
    logic [2:0] frame_sel;
    logic [5:0] byte_sel;
    logic [7:0] byte_i;
    logic [6:0] frame_len_i;
    logic       bit_req_i = 1'b0;
    logic       bit_o;
    logic       busy_o;
    logic       done_o;

    logic [7:0] mem  [MAXF][MAXB];
    logic [6:0] lens [MAXF];
    logic       exp_bits [NBITS];
    logic       got_bits [NBITS];
    int         exp_n;
    int         ones_m;
    int         n_checks = 0;
    int         n_fail = 0;

    always #2 clk = ~clk;

    assign byte_i      = mem[frame_sel][byte_sel];
    assign frame_len_i = lens[frame_sel];

    ax25_bit_serializer #(
        .MAX_FRAMES (MAXF),
        .MAX_BYTES  (MAXB),
        .PRE_FLAGS  (PRE),
        .HDR_FLAGS  (HDR),
        .SEP_FLAGS  (SEP),
        .TAIL_FLAGS (TAIL)
    ) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .frame_count_i (frame_count_i),
        .frame_sel_o   (frame_sel),
        .byte_sel_o    (byte_sel),
        .byte_i        (byte_i),
        .frame_len_i   (frame_len_i),
        .bit_req_i     (bit_req_i),
        .bit_o         (bit_o),
        .busy_o        (busy_o),
        .done_o        (done_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [15:0] crc_next(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[0] ^ b;
        return (c >> 1) ^ (fb ? 16'h8408 : 16'h0000);
    endfunction

    task automatic push_raw(input logic b);
        exp_bits[exp_n] = b;
        exp_n++;
    endtask

    task automatic push_stuffed(input logic b);
        push_raw(b);
        ones_m = b ? ones_m + 1 : 0;
        if (ones_m == 5) begin
            push_raw(1'b0);
            ones_m = 0;
        end
    endtask

    task automatic push_flag();
        ones_m = 0;
        for (int j = 0; j < 8; j++) push_raw(8'h7E >> j);
    endtask

    task automatic build(input int nfr);
        logic [15:0] c;
        exp_n  = 0;
        ones_m = 0;
        for (int k = 0; k < PRE + HDR; k++) push_flag();
        for (int f = 0; f < nfr; f++) begin
            c = 16'hFFFF;
            for (int k = 0; k < int'(lens[f]); k++)
                for (int j = 0; j < 8; j++) begin
                    c = crc_next(c, mem[f][k][j]);
                    push_stuffed(mem[f][k][j]);
                end
            c = ~c;
            for (int j = 0; j < 16; j++) push_stuffed(c[j]);
            for (int k = 0; k < SEP; k++) push_flag();
        end
        for (int k = 0; k < TAIL; k++) push_flag();
    endtask

    task automatic fill(input int nfr, input int la, input int lb, input int mode);
        for (int f = 0; f < MAXF; f++) begin
            lens[f] = (f == 0) ? 7'(la) : 7'(lb);
            for (int k = 0; k < MAXB; k++)
                case (mode)
                    1: mem[f][k] = 8'hFF;
                    2: mem[f][k] = 8'h31 + 8'(k);
                    3: mem[f][k] = (k % 2 == 0) ? 8'hF8 : 8'h1F;
                    default: mem[f][k] = 8'(k * 7 + f * 29 + 3);
                endcase
        end
        if (nfr < MAXF) lens[nfr] = 7'd0;
    endtask

    // run one transmission and compare every bit with the model
    task automatic run_tx(input int nfr, input int gap, input bit mid_start);
        int  early_done;
        logic held;
        early_done = 0;
        @(negedge clk);
        frame_count_i = 4'(nfr);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R2 busy after start", {31'd0, busy_o}, 32'd1);
        bit_req_i = 1'b1;
        for (int i = 0; i < exp_n; i++) begin
            @(negedge clk);
            if (gap != 0 || i == exp_n - 1) bit_req_i = 1'b0;
            got_bits[i] = bit_o;
            if (i < HEAD_BITS)
                chk("R4 flag bit", {31'd0, bit_o}, {31'd0, exp_bits[i]});
            else if (i >= exp_n - TAIL * 8)
                chk("R8 tail bit", {31'd0, bit_o}, {31'd0, exp_bits[i]});
            else
                chk("R5/R6/R7/R8 frame bit", {31'd0, bit_o}, {31'd0, exp_bits[i]});
            if (i == exp_n - 1) begin
                chk("R9 done with last bit", {31'd0, done_o}, 32'd1);
                chk("R9 busy low at done", {31'd0, busy_o}, 32'd0);
            end else if (done_o) begin
                early_done++;
            end
            if (gap != 0 && i != exp_n - 1) begin
                held = bit_o;
                for (int g = 0; g < gap; g++) begin
                    if (mid_start && i == 40 && g == 0) start_i = 1'b1;
                    @(negedge clk);
                    start_i = 1'b0;
                end
                chk("R3 bit held without request", {31'd0, bit_o}, {31'd0, held});
                bit_req_i = 1'b1;
            end
        end
        chk("R9 no early done", early_done, 0);
        @(negedge clk);
        chk("R9 done single cycle", {31'd0, done_o}, 32'd0);
        chk("R2 idle after transmission", {31'd0, busy_o}, 32'd0);
    endtask

    // watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R3 actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] c;
        logic [15:0] fcs_got;
        logic        held;
        fill(0, 0, 0, 0);

        // R1: outputs during reset
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", {31'd0, busy_o}, 32'd0);
        chk("R1 done in reset", {31'd0, done_o}, 32'd0);
        chk("R1 bit in reset", {31'd0, bit_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after reset", {31'd0, busy_o}, 32'd0);
        chk("R1 bit after reset", {31'd0, bit_o}, 32'd0);

        // R7: the bench model itself against the known check value
        c = 16'hFFFF;
        for (int k = 0; k < 9; k++)
            for (int j = 0; j < 8; j++) c = crc_next(c, (8'h31 + 8'(k)) >> j);
        chk("R7 model check value", {16'd0, ~c}, 32'h906E);

        // vector table walk
        for (int v = 0; v < 6; v++) begin
            fill(int'(VEC[v][39:32]), int'(VEC[v][31:24]), int'(VEC[v][23:16]),
                 int'(VEC[v][15:8]));
            build(int'(VEC[v][39:32]));
            run_tx(int'(VEC[v][39:32]), int'(VEC[v][7:0]), v == 2);
            if (v == 0) begin
                // R7: "123456789" check sequence right after the payload
                for (int j = 0; j < 16; j++) fcs_got[j] = got_bits[HEAD_BITS + 72 + j];
                chk("R7 check sequence of 123456789", {16'd0, fcs_got}, 32'h906E);
            end
            if (v == 1) begin
                // R6: zero inserted after the first five payload ones
                chk("R6 stuffed zero", {31'd0, got_bits[HEAD_BITS + 5]}, 32'd0);
                chk("R6 run restarts", {31'd0, got_bits[HEAD_BITS + 6]}, 32'd1);
            end
            if (v == 3) begin
                // R7: empty first frame gives sixteen zero bits
                for (int j = 0; j < 16; j++) fcs_got[j] = got_bits[HEAD_BITS + j];
                chk("R7 empty frame check sequence", {16'd0, fcs_got}, 32'h0000);
            end
        end

        // R2: zero frame count is ignored
        @(negedge clk);
        frame_count_i = 4'd0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R2 zero count ignored", {31'd0, busy_o}, 32'd0);

        // R3: requests while idle change nothing
        held = bit_o;
        bit_req_i = 1'b1;
        repeat (3) @(negedge clk);
        bit_req_i = 1'b0;
        chk("R3 idle request bit", {31'd0, bit_o}, {31'd0, held});
        chk("R3 idle request done", {31'd0, done_o}, 32'd0);
        chk("R3 idle request busy", {31'd0, busy_o}, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule